// File: doc/BRIEF.md
# Vectored Interrupt Controller with Split Normal/Critical Outputs

This block gathers 32 interrupt lines and conditions each one on its own terms. A per-line polarity bit selects active-high or active-low. A per-line mode bit selects level or edge capture. The conditioned lines are captured in a status register. The enable register masks status, and a class register sorts each enabled line onto one of two request outputs: a normal request and a critical request.

For critical work, the block also produces a ready-made handler address. A priority search looks for the first pending critical line, starting from either line 0 or line 31 as software chooses. The address is a programmable base plus a fixed 512-byte step for each position the winner lies from the starting end. Software reaches every register through a single-cycle register port with a 3-bit address. Reads are combinational and writes take effect at the clock edge.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The polarity register decides how each input is seen. A polarity bit of 1 makes the line active when high. A polarity bit of 0 makes it active when low.
- R2: When a line's trigger bit is 0 (level mode), its status bit takes the active level of the line one clock later. Writes to the status register do not change that bit.
- R3: When a line's trigger bit is 1 (edge mode), its status bit sets on the clock that follows an inactive-to-active change and then holds. Writing 1 to that bit at address 0 clears it. If a new edge arrives in the same cycle as the clear, the set wins.
- R4: `irqNorm` is high exactly while some line has status, enable and a critical bit of 0.
- R5: `irqCrit` is high exactly while some line has status, enable and a critical bit of 1.
- R6: A read of address 5 returns status AND enable.
- R7: The vector is the configuration value with bits 1:0 cleared, plus 512 times the distance of the first pending critical line from the search start. With configuration bit 0 = 1 the search starts at line 31 and moves down. With bit 0 = 0 it starts at line 0 and moves up. The vector appears on `vecAddr` and at address 7.
- R8: A write to the vector configuration register (address 6) stores the written value with bit 1 forced to 0.
- R9: The vector reads 0 while no critical line is pending.
- R10: Reset clears the status, enable, critical, polarity, trigger and vector configuration registers, and the vector reads 0.
- R11: The register addresses are: 0 status, 1 enable, 2 critical (1 = critical class), 3 polarity, 4 trigger, 5 masked status (read only), 6 vector configuration, 7 vector (read only). Registers are 32 bits wide, and bit n belongs to line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 32 | Raw interrupt lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| irqNorm | output | 1 | Normal interrupt request |
| irqCrit | output | 1 | Critical interrupt request |
| vecAddr | output | 32 | Computed critical handler address |

## Verification
The hardest state to reach is a status bit in edge mode that stays set after its input has gone inactive again. A careless setup sequence creates stray edges in that mode: changing polarity while a line is in edge mode flips its active level and latches an edge nobody intended. The stimulus avoids this by programming polarity first, switching only the target line to edge mode afterwards, and only then pulsing that line. The vector search is driven from a table of base/direction/pattern cases. The table covers both ends of the search and a base whose low bits must be dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    ADDR_STATUS = 3'd0,
    ADDR_ENABLE = 3'd1,
    ADDR_CRIT   = 3'd2,
    ADDR_POLAR  = 3'd3,
    ADDR_TRIG   = 3'd4,
    ADDR_MASKED = 3'd5,
    ADDR_VCFG   = 3'd6,
    ADDR_VEC    = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrCrit;
    logic wrPolar;
    logic wrTrig;
    logic wrVcfg;
  } regStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  output regStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (regWrEn) begin
      unique case (regAddr_e'(regAddr))
        ADDR_STATUS: strobe.wrStatus = 1'b1;
        ADDR_ENABLE: strobe.wrEnable = 1'b1;
        ADDR_CRIT:   strobe.wrCrit   = 1'b1;
        ADDR_POLAR:  strobe.wrPolar  = 1'b1;
        ADDR_TRIG:   strobe.wrTrig   = 1'b1;
        ADDR_VCFG:   strobe.wrVcfg   = 1'b1;
        default:     strobe = '0; // read-only addresses ignore writes
      endcase
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int DATA_W      = 32,
  parameter int STRIDE_LOG2 = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  regStrobe_t         strobe,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqNorm,
  output logic               irqCrit,
  output logic [DATA_W-1:0]  vecAddr
);
  logic [NUM_IRQ-1:0] statusQ, enableQ, critQ, polarQ, trigQ, prevActQ;
  logic [DATA_W-1:0]  vcfgQ;
  logic [NUM_IRQ-1:0] active, clearMask, statusNext, maskedSt, normPend, critPend;

  assign active    = ~(irqIn ^ polarQ);
  assign clearMask = strobe.wrStatus ? regWrData[NUM_IRQ-1:0] : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gLine
    if (1) begin : gCapture
      always_comb begin
        if (trigQ[g])
          statusNext[g] = (statusQ[g] & ~clearMask[g]) | (active[g] & ~prevActQ[g]);
        else
          statusNext[g] = active[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      critQ    <= '0;
      polarQ   <= '0;
      trigQ    <= '0;
      prevActQ <= '0;
      vcfgQ    <= '0;
    end else begin
      statusQ  <= statusNext;
      prevActQ <= active;
      if (strobe.wrEnable) enableQ <= regWrData[NUM_IRQ-1:0];
      if (strobe.wrCrit)   critQ   <= regWrData[NUM_IRQ-1:0];
      if (strobe.wrPolar)  polarQ  <= regWrData[NUM_IRQ-1:0];
      if (strobe.wrTrig)   trigQ   <= regWrData[NUM_IRQ-1:0];
      if (strobe.wrVcfg)   vcfgQ   <= regWrData & ~DATA_W'(2);
    end
  end

  assign maskedSt = statusQ & enableQ;
  assign normPend = maskedSt & ~critQ;
  assign critPend = maskedSt & critQ;
  assign irqNorm  = |normPend;
  assign irqCrit  = |critPend;

  // Priority search over the pending critical lines
  logic              vecHit;
  logic [DATA_W-1:0] vecDist;
  always_comb begin
    vecHit  = 1'b0;
    vecDist = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (!vecHit && critPend[vcfgQ[0] ? (NUM_IRQ - 1 - i) : i]) begin
        vecHit  = 1'b1;
        vecDist = DATA_W'(i);
      end
    end
  end
  assign vecAddr = vecHit ? ((vcfgQ & ~DATA_W'(3)) + (vecDist << STRIDE_LOG2)) : '0;

  always_comb begin
    unique case (regAddr_e'(regAddr))
      ADDR_STATUS: regRdData = DATA_W'(statusQ);
      ADDR_ENABLE: regRdData = DATA_W'(enableQ);
      ADDR_CRIT:   regRdData = DATA_W'(critQ);
      ADDR_POLAR:  regRdData = DATA_W'(polarQ);
      ADDR_TRIG:   regRdData = DATA_W'(trigQ);
      ADDR_MASKED: regRdData = DATA_W'(maskedSt);
      ADDR_VCFG:   regRdData = vcfgQ;
      ADDR_VEC:    regRdData = vecAddr;
      default:     regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_IRQ     = 32,
  parameter int DATA_W      = 32,
  parameter int STRIDE_LOG2 = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqNorm,
  output logic               irqCrit,
  output logic [DATA_W-1:0]  vecAddr
);
  regStrobe_t strobe;

  irqc_ctrl uCtrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  irqc_datapath #(
    .NUM_IRQ     (NUM_IRQ),
    .DATA_W      (DATA_W),
    .STRIDE_LOG2 (STRIDE_LOG2)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .irqIn     (irqIn),
    .strobe    (strobe),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .irqNorm   (irqNorm),
    .irqCrit   (irqCrit),
    .vecAddr   (vecAddr)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              irqNorm,
  input logic              irqCrit,
  input logic [DATA_W-1:0] vecAddr
);
  p_vec_zero_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !irqCrit |-> vecAddr == '0);

  p_vec_align_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqCrit |-> vecAddr[1:0] == 2'b00);

  p_vec_readback_r7: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 3'd7 |-> regRdData == vecAddr);

  p_vcfg_bit1_r8: assert property (@(posedge clk) disable iff (!rstN)
    regAddr == 3'd6 |-> regRdData[1] == 1'b0);

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 3'd5 && !irqNorm && !irqCrit) |-> regRdData == '0);

  p_reset_release_r10: assert property (@(posedge clk)
    (!rstN) |=> (!irqNorm && !irqCrit));
endmodule

bind irq_vec_ctrl irqc_checker #(.DATA_W(DATA_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .irqNorm   (irqNorm),
  .irqCrit   (irqCrit),
  .vecAddr   (vecAddr)
);

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] irqIn = '1;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqNorm, irqCrit;
  logic [31:0] vecAddr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irq_vec_ctrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqNorm(irqNorm), .irqCrit(irqCrit), .vecAddr(vecAddr)
  );

  // {configuration, input pattern, expected vector}
  localparam logic [95:0] VEC_TBL [6] = '{
    {32'h1000_0000, 32'h0000_0010, 32'h1000_0800},
    {32'h1000_0001, 32'h0000_0010, 32'h1000_3600},
    {32'h2000_0003, 32'h8000_0001, 32'h2000_0000},
    {32'h2000_0002, 32'h8000_0100, 32'h2000_1000},
    {32'h0000_0005, 32'h0000_0001, 32'h0000_3E04},
    {32'h1234_5601, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #0.1 d = regRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk); step(); step();
    rstN = 1'b1;
    step();
    // Reset state (R10); inputs high with active-low polarity are inactive
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R10 reg %0d after reset", a), v, 32'h0);
    end
    check("R10 outputs after reset", {30'h0, irqNorm, irqCrit}, 32'h0);

    // Table-driven vector search (R7, R9, R5)
    irqIn = '0;
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
    foreach (VEC_TBL[k]) begin
      wr(3'd6, VEC_TBL[k][95:64]);
      irqIn = VEC_TBL[k][63:32];
      step();
      check($sformatf("R7 vector case %0d", k), vecAddr, VEC_TBL[k][31:0]);
      check($sformatf("R5 critical output case %0d", k), {31'h0, irqCrit},
            {31'h0, VEC_TBL[k][63:32] != 0});
      check($sformatf("R4 normal quiet case %0d", k), {31'h0, irqNorm}, 32'h0);
    end
    rd(3'd7, v);
    check("R9 vector register idle", v, 32'h0);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v);
    check("R8 configuration bit 1 cleared", v, 32'hFFFF_FFFD);

    // Normal class, active-low level input (R1, R4, R2)
    wr(3'd1, 32'h0);
    irqIn = 32'hFFFF_FFFF;
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h0000_0008);
    step();
    check("R1 high input inactive when active-low", {31'h0, irqNorm}, 32'h0);
    irqIn[3] = 1'b0;
    step();
    check("R4 normal output from active-low line", {31'h0, irqNorm}, 32'h1);
    check("R5 critical stays low", {31'h0, irqCrit}, 32'h0);
    wr(3'd0, 32'h0000_0008);
    check("R2 status write ignored in level mode", {31'h0, irqNorm}, 32'h1);
    rd(3'd0, v);
    check("R2 level status bit held", v & 32'h8, 32'h8);
    irqIn[3] = 1'b1;
    step();
    check("R2 status follows level off", {31'h0, irqNorm}, 32'h0);

    // Edge mode on line 5 (R3)
    wr(3'd3, 32'h0000_0020);
    wr(3'd4, 32'h0000_0020);
    wr(3'd0, 32'h0000_0020);
    wr(3'd1, 32'h0000_0020);
    irqIn[5] = 1'b0;
    step();
    check("R3 no edge yet", {31'h0, irqNorm}, 32'h0);
    irqIn[5] = 1'b1;
    step();
    irqIn[5] = 1'b0;
    step(); step();
    check("R3 edge latched after input fell", {31'h0, irqNorm}, 32'h1);
    wr(3'd1, 32'h0000_0028);
    rd(3'd5, v);
    check("R6 masked status read", v, 32'h0000_0020);
    wr(3'd0, 32'h0000_0020);
    check("R3 write-one clears edge status", {31'h0, irqNorm}, 32'h0);
    // Set wins over a simultaneous clear
    irqIn[5] = 1'b1;
    regWrEn = 1'b1; regAddr = 3'd0; regWrData = 32'h0000_0020;
    step();
    regWrEn = 1'b0;
    check("R3 new edge beats clear", {31'h0, irqNorm}, 32'h1);
    rd(3'd0, v);
    check("R11 status bit position", v & 32'h20, 32'h20);

    // Mid-run reset (R10)
    wr(3'd2, 32'h0000_00F0);
    wr(3'd6, 32'h0000_1001);
    irqIn = 32'hFFFF_FFFF;
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R10 reg %0d after mid-run reset", a), v, 32'h0);
    end
    check("R10 vector output after reset", vecAddr, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule